// File: doc/BRIEF.md
# Maskable Flag Interrupt Controller

This block merges three active-low status flags into one active-low interrupt line to a local microprocessor. The flags report that the packet FIFO holds data, that a transfer has ended, and that a sector is ready. Each flag reaches the interrupt line only while its own enable bit is set. The enable bits sit in the upper three bits of an 8-bit control register that firmware writes. The register can also be read back, and its five unused low bits read as zero.

Two hardware events also change the enable bits. When the host writes the packet command byte (A0h) while host interrupts are enabled and the drive is selected, the transfer-end enable sets itself. Any one of the host, firmware and decoder reset pulses clears the sector-ready enable. The chip reset clears every enable.

The interrupt line is taken from a register, so it changes one clock after the flags or enables that drive it. This keeps glitches off the pin. Generating the flags themselves is outside this block.

Top module: `flag_irq_ctrl`

## Requirements
- R1: After chip reset (`rst_n` low at a clock edge) all enable bits are 0, `ctrl_rdata` reads 00h and `irq_n` is high.
- R2: When bit 7 of the control register is 1 and `fne_n` is low, `irq_n` is low.
- R3: When bit 6 of the control register is 1 and `tend_n` is low, `irq_n` is low.
- R4: When bit 5 of the control register is 1 and `srdy_n` is low, `irq_n` is low.
- R5: `irq_n` is high whenever no source has both its enable bit at 1 and its flag low; a low flag whose enable is 0 has no effect.
- R6: A `cmd_wr` pulse with `cmd_byte` = A0h while `host_ie` and `drv_sel` are both high sets bit 6 from the next cycle and leaves bits 7 and 5 unchanged. Any other opcode, or either qualifier low, leaves bit 6 unchanged.
- R7: A one-cycle pulse on `host_rst`, `fw_rst` or `dec_rst` clears bit 5 from the next cycle and leaves bits 7 and 6 unchanged. The clear wins over a firmware write in the same cycle.
- R8: Control bits 4..0 always read back as 0, and writing them changes neither the readback nor `irq_n`.
- R9: If a firmware write and a packet-command auto-enable fall in the same cycle, bit 6 ends at 1 and bits 7 and 5 take the written values.
- R10: `irq_n` is registered. It changes at the first clock edge after the flag or enable change that causes it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, synchronous |
| host_rst | input | 1 | Host reset pulse; clears the sector-ready enable |
| fw_rst | input | 1 | Firmware reset pulse; clears the sector-ready enable |
| dec_rst | input | 1 | Decoder reset pulse; clears the sector-ready enable |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_rdata | output | 8 | Control register readback; bits 4..0 are zero |
| cmd_wr | input | 1 | Host command write strobe |
| cmd_byte | input | 8 | Host command opcode |
| host_ie | input | 1 | Host interrupt enable qualifier |
| drv_sel | input | 1 | Drive selected qualifier |
| fne_n | input | 1 | Packet FIFO not empty flag, active low |
| tend_n | input | 1 | Transfer end flag, active low |
| srdy_n | input | 1 | Sector ready flag, active low |
| irq_n | output | 1 | Interrupt to the microprocessor, active low, registered |

## Verification
Two pairs of events can land on the same edge. A firmware write can meet a packet-command auto-enable, and a firmware write can meet a reset pulse that clears the sector-ready enable. The bench drives both strobes in one cycle, on purpose, with write data that would give the opposite result. It then reads the control register back one edge later. The auto-enable must win bit 6 while the written values still reach bits 7 and 5, and the reset must win bit 5.

// File: rtl/fic_pkg.sv
package fic_pkg;
    localparam int DATA_W   = 8;
    localparam int SRC_N    = 3;
    // Source indices within the enable vector; enable i lives at register bit (DATA_W-SRC_N+i)
    localparam int SRC_SRDY = 0;
    localparam int SRC_TEND = 1;
    localparam int SRC_FNE  = 2;
    localparam logic [DATA_W-1:0] OPC_PACKET = 8'hA0;

    typedef struct packed {
        logic [SRC_N-1:0] en;
    } en_state_t;

    typedef struct packed {
        logic irq_n;
    } irq_state_t;
endpackage

// File: rtl/fic_auto_detect.sv
module fic_auto_detect #(
    parameter int DATA_W = fic_pkg::DATA_W,
    parameter logic [DATA_W-1:0] OPCODE = fic_pkg::OPC_PACKET
) (
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              host_ie,
    input  logic              drv_sel,
    output logic              auto_set
);
    always_comb begin
        auto_set = cmd_wr && (cmd_byte == OPCODE) && host_ie && drv_sel;
    end
endmodule

// File: rtl/fic_enable_reg.sv
module fic_enable_reg
    import fic_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int N_SRC = SRC_N,
    parameter int AUTO_IDX = SRC_TEND,
    parameter int CLR_IDX  = SRC_SRDY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [D_W-1:0]   wr_data,
    input  logic             auto_set,
    input  logic             soft_clr,
    output logic [N_SRC-1:0] en
);
    localparam int LSB = D_W - N_SRC;

    logic [N_SRC-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (wr_en)    en_d = wr_data[D_W-1:LSB];
        if (auto_set) en_d[AUTO_IDX] = 1'b1;   // auto-enable wins over a write
        if (soft_clr) en_d[CLR_IDX]  = 1'b0;   // reset sources win over a write
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en = en_q;

    p_auto_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_set |=> en_q[AUTO_IDX]);
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !en_q[CLR_IDX]);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !auto_set && !soft_clr) |=> $stable(en_q));
endmodule

// File: rtl/fic_combine.sv
module fic_combine #(
    parameter int N_SRC = fic_pkg::SRC_N
) (
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] flag_n,
    output logic             any_req
);
    logic [N_SRC-1:0] hit;
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = en[i] & ~flag_n[i];
    end
    assign any_req = |hit;
endmodule

// File: rtl/flag_irq_ctrl.sv
module flag_irq_ctrl
    import fic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              fw_rst,
    input  logic              dec_rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_wdata,
    output logic [DATA_W-1:0] ctrl_rdata,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              host_ie,
    input  logic              drv_sel,
    input  logic              fne_n,
    input  logic              tend_n,
    input  logic              srdy_n,
    output logic              irq_n
);
    localparam int LSB = DATA_W - SRC_N;

    logic             auto_set;
    logic             soft_clr;
    logic [SRC_N-1:0] en;
    logic [SRC_N-1:0] flag_n;
    logic             any_req;
    irq_state_t       irq_d, irq_q;

    assign soft_clr = host_rst | fw_rst | dec_rst;

    always_comb begin
        flag_n           = '1;
        flag_n[SRC_SRDY] = srdy_n;
        flag_n[SRC_TEND] = tend_n;
        flag_n[SRC_FNE]  = fne_n;
    end

    fic_auto_detect #(.DATA_W(DATA_W), .OPCODE(OPC_PACKET)) u_auto (
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .host_ie(host_ie),
        .drv_sel(drv_sel), .auto_set(auto_set)
    );

    fic_enable_reg #(.D_W(DATA_W), .N_SRC(SRC_N)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_data(ctrl_wdata),
        .auto_set(auto_set), .soft_clr(soft_clr), .en(en)
    );

    fic_combine #(.N_SRC(SRC_N)) u_comb (
        .en(en), .flag_n(flag_n), .any_req(any_req)
    );

    always_comb begin
        irq_d       = irq_q;
        irq_d.irq_n = ~any_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '{irq_n: 1'b1};
        else        irq_q <= irq_d;
    end

    assign irq_n      = irq_q.irq_n;
    assign ctrl_rdata = {en, {LSB{1'b0}}};

    p_fne_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[DATA_W-1] && !fne_n) |=> !irq_n);
    p_tend_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[DATA_W-2] && !tend_n) |=> !irq_n);
    p_srdy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[DATA_W-3] && !srdy_n) |=> !irq_n);
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_rdata[DATA_W-1] && !fne_n) && !(ctrl_rdata[DATA_W-2] && !tend_n)
         && !(ctrl_rdata[DATA_W-3] && !srdy_n)) |=> irq_n);
endmodule

// File: tb/flag_irq_ctrl_tb.sv
`timescale 1ns/1ps
module flag_irq_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n, host_rst, fw_rst, dec_rst, ctrl_wr, cmd_wr, host_ie, drv_sel;
    logic fne_n, tend_n, srdy_n, irq_n;
    logic [7:0] ctrl_wdata, ctrl_rdata, cmd_byte;
    int tests = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flag_irq_ctrl u_dut (.*);

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        host_rst = 0; fw_rst = 0; dec_rst = 0; ctrl_wr = 0; cmd_wr = 0;
        ctrl_wdata = 0; cmd_byte = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = v;
        @(negedge clk); idle();
    endtask

    task automatic cmd(input logic [7:0] op, input logic ie, input logic sel);
        @(negedge clk); cmd_wr = 1; cmd_byte = op; host_ie = ie; drv_sel = sel;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        check(ctrl_rdata == 8'h00, "R1 readback", ctrl_rdata, 8'h00);
        check(irq_n == 1'b1, "R1 irq_n", {7'b0, irq_n}, 8'h01);
    endtask

    task automatic t_low_bits();
        wr(8'hFF);
        check(ctrl_rdata == 8'hE0, "R8 readback FF", ctrl_rdata, 8'hE0);
        wr(8'h1F);
        check(ctrl_rdata == 8'h00, "R8 readback 1F", ctrl_rdata, 8'h00);
        fne_n = 0; tend_n = 0; srdy_n = 0;
        @(negedge clk); @(negedge clk);
        check(irq_n == 1'b1, "R8 low bits no irq", {7'b0, irq_n}, 8'h01);
        fne_n = 1; tend_n = 1; srdy_n = 1;
        @(negedge clk);
    endtask

    // src: 7 = fifo (R2), 6 = transfer end (R3), 5 = sector ready (R4)
    task automatic t_source(input int src, input string tag);
        wr(8'h01 << src);
        if (src == 7) fne_n = 0; else if (src == 6) tend_n = 0; else srdy_n = 0;
        #1;
        check(irq_n == 1'b1, "R10 not before edge", {7'b0, irq_n}, 8'h01);
        @(negedge clk);
        check(irq_n == 1'b0, tag, {7'b0, irq_n}, 8'h00);
        fne_n = 1; tend_n = 1; srdy_n = 1;
        @(negedge clk);
        check(irq_n == 1'b1, "R10 release", {7'b0, irq_n}, 8'h01);
        // other flags low but masked
        if (src != 7) fne_n = 0;
        if (src != 6) tend_n = 0;
        if (src != 5) srdy_n = 0;
        @(negedge clk); @(negedge clk);
        check(irq_n == 1'b1, "R5 masked flags", {7'b0, irq_n}, 8'h01);
        fne_n = 1; tend_n = 1; srdy_n = 1;
        wr(8'h00);
    endtask

    task automatic t_auto();
        wr(8'h00);
        cmd(8'hA0, 0, 1);
        check(ctrl_rdata == 8'h00, "R6 ie low", ctrl_rdata, 8'h00);
        cmd(8'hA0, 1, 0);
        check(ctrl_rdata == 8'h00, "R6 sel low", ctrl_rdata, 8'h00);
        cmd(8'hA1, 1, 1);
        check(ctrl_rdata == 8'h00, "R6 other opcode", ctrl_rdata, 8'h00);
        wr(8'hA0);
        cmd(8'hA0, 1, 1);
        check(ctrl_rdata == 8'hE0, "R6 auto set", ctrl_rdata, 8'hE0);
        host_ie = 0; drv_sel = 0;
    endtask

    task automatic t_clears();
        for (int k = 0; k < 3; k++) begin
            wr(8'hE0);
            @(negedge clk);
            if (k == 0) host_rst = 1; else if (k == 1) fw_rst = 1; else dec_rst = 1;
            @(negedge clk); idle();
            check(ctrl_rdata == 8'hC0, "R7 reset pulse", ctrl_rdata, 8'hC0);
        end
        @(negedge clk); fw_rst = 1; ctrl_wr = 1; ctrl_wdata = 8'h20;
        @(negedge clk); idle();
        check(ctrl_rdata == 8'h00, "R7 clear beats write", ctrl_rdata, 8'h00);
    endtask

    task automatic t_collide();
        wr(8'h40);
        @(negedge clk); ctrl_wr = 1; ctrl_wdata = 8'hA0;
        cmd_wr = 1; cmd_byte = 8'hA0; host_ie = 1; drv_sel = 1;
        @(negedge clk); idle();
        check(ctrl_rdata == 8'hE0, "R9 auto beats write", ctrl_rdata, 8'hE0);
        host_ie = 0; drv_sel = 0;
        wr(8'h00);
    endtask

    initial begin
        rst_n = 0; idle(); host_ie = 0; drv_sel = 0;
        fne_n = 1; tend_n = 1; srdy_n = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_low_bits();
        t_source(7, "R2 fifo irq");
        t_source(6, "R3 tend irq");
        t_source(5, "R4 srdy irq");
        t_auto();
        t_clears();
        t_collide();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule